// File: doc/BRIEF.md
# Return-Address Hash Store/Check Unit

This block runs two fixed-point instructions that guard saved return addresses. A hash-store takes a digest of two register values and writes it, as one 64-bit word, to a slot just below a base register. A hash-check computes the same digest and reads the slot back. If the stored word does not match, it raises a program trap. The unit decodes the 32-bit instruction word and forms the effective address. It drives a digest engine through a request/acknowledge handshake, since the digest engine holds the key. It then issues a single memory request and reports completion.

The slot address is the base register value plus a negative doubleword displacement. A 6-bit field split across the instruction picks the offset. When the hash feature is disabled, both instructions retire as no-ops. A zero base-register field is an invalid form and retires with an illegal-instruction flag.

Top module: `rh_exec`

## Requirements
- R1: An instruction word is accepted only when bits 31:26 equal 31 and bits 10:1 equal 1011010010 (store) or 1011110010 (check). Any other word produces no busy, no request and no completion pulse.
- R2: The effective address is the base value plus a displacement, where the displacement is all ones above bit 8, zero in bits 2:0, and bits 8:3 hold the field {instr[0], instr[25:21]}. This covers offsets from -512 to -8 bytes.
- R3: With the feature enabled and a base-register field (bits 20:16) of zero, the unit pulses `illegal_o` with `done_o` in the cycle after acceptance. It issues no digest or memory request.
- R4: With `feat_en_i` low, an accepted instruction pulses `done_o` in the next cycle, without `illegal_o`, without trap and without any request, even when the base-register field is zero.
- R5: For a valid instruction, `dig_req_o` rises in the cycle after acceptance. It carries the RA and RB values and holds them steady until `dig_ack_i`.
- R6: A store issues one memory write of the acknowledged digest to the effective address, with `mem_we_o` high.
- R7: A check issues one memory read of the effective address, with `mem_we_o` low. If the read data equals the digest, it completes with `done_o` and no trap.
- R8: If a check reads data that differs from the digest, `trap_o` pulses for one cycle together with `done_o`, and `trap_addr_o` holds the effective address.
- R9: `busy_o` is high from the cycle after acceptance until the memory acknowledge. Instruction words presented while busy are ignored.
- R10: Digest and memory requests never overlap. A memory request holds its address, direction and data until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| feat_en_i | input | 1 | Hash instructions enabled |
| instr_valid_i | input | 1 | Instruction word presented |
| instr_i | input | 32 | Instruction word |
| ra_val_i | input | 64 | Base register value |
| rb_val_i | input | 64 | Second register value |
| busy_o | output | 1 | Instruction in flight |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Invalid-form pulse |
| trap_o | output | 1 | Hash mismatch trap pulse |
| trap_addr_o | output | 64 | Address of the failing check |
| dig_req_o | output | 1 | Digest request |
| dig_a_o | output | 64 | Digest operand from RA |
| dig_b_o | output | 64 | Digest operand from RB |
| dig_ack_i | input | 1 | Digest acknowledge |
| dig_val_i | input | 64 | Digest value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 64 | Memory address |
| mem_wdata_o | output | 64 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 64 | Read data |

## Verification
No-op and illegal completions are due one cycle after the accepting edge. The digest request is due one cycle after acceptance, and the memory request one cycle after the digest acknowledge. Completion and trap are due one cycle after the memory acknowledge. The driver task steps one falling edge at a time and checks each request exactly in its due cycle. The scoreboard monitor samples `done_o` on falling edges and pairs each pulse with the outcome queued when the instruction was issued. An unexpected pulse, or one left over in the queue, counts as a failure.

// File: rtl/rh_pkg.sv
package rh_pkg;
  localparam int unsigned XLEN = 64;
  localparam int unsigned ILEN = 32;
  localparam int unsigned DISP_W = 6;
  localparam int unsigned DISP_SHIFT = 3;
  localparam logic [5:0] OPC_X = 6'd31;
  localparam logic [9:0] XO_HSTORE = 10'b1011010010;
  localparam logic [9:0] XO_HCHECK = 10'b1011110010;

  typedef enum logic [1:0] {ST_IDLE, ST_DIG, ST_MEM} state_e;
endpackage

// File: rtl/rh_decode.sv
module rh_decode
  import rh_pkg::*;
(
  input  logic [ILEN-1:0]   instr_i,
  output logic              hit_o,
  output logic              store_o,
  output logic              ra_zero_o,
  output logic [DISP_W-1:0] disp_o
);
  logic unused_rb;
  logic [9:0] xo;

  assign unused_rb = ^instr_i[15:11];
  assign xo        = instr_i[10:1];
  assign store_o   = (xo == XO_HSTORE);
  assign hit_o     = (instr_i[31:26] == OPC_X) && (store_o || xo == XO_HCHECK);
  assign ra_zero_o = (instr_i[20:16] == 5'd0);
  // top bit of the split field sits in the last instruction bit
  assign disp_o    = {instr_i[0], instr_i[25:21]};
endmodule

// File: rtl/rh_ea_gen.sv
module rh_ea_gen #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned DISP_W = 6,
  parameter int unsigned DISP_SHIFT = 3
) (
  input  logic [XLEN-1:0]   base_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [XLEN-1:0]   ea_o
);
  localparam int unsigned TOP_W = XLEN - DISP_W - DISP_SHIFT;
  localparam logic [XLEN-1:0] NEG_BASE = {XLEN{1'b1}} << (DISP_W + DISP_SHIFT);

  logic [XLEN-1:0] disp_ext;

  assign disp_ext = NEG_BASE | {{TOP_W{1'b0}}, disp_i, {DISP_SHIFT{1'b0}}};
  assign ea_o     = base_i + disp_ext;
endmodule

// File: rtl/rh_exec.sv
module rh_exec
  import rh_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            feat_en_i,
  input  logic            instr_valid_i,
  input  logic [ILEN-1:0] instr_i,
  input  logic [XLEN-1:0] ra_val_i,
  input  logic [XLEN-1:0] rb_val_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            illegal_o,
  output logic            trap_o,
  output logic [XLEN-1:0] trap_addr_o,
  output logic            dig_req_o,
  output logic [XLEN-1:0] dig_a_o,
  output logic [XLEN-1:0] dig_b_o,
  input  logic            dig_ack_i,
  input  logic [XLEN-1:0] dig_val_i,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [XLEN-1:0] mem_addr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [XLEN-1:0] mem_rdata_i
);
  state_e            state_q;
  logic              dec_hit, dec_store, dec_ra_zero;
  logic [DISP_W-1:0] dec_disp;
  logic [XLEN-1:0]   ea_d;
  logic              store_q, done_q, illegal_q, trap_q;
  logic [XLEN-1:0]   ea_q, a_q, b_q, dig_q, taddr_q;

  rh_decode i_decode (
    .instr_i   (instr_i),
    .hit_o     (dec_hit),
    .store_o   (dec_store),
    .ra_zero_o (dec_ra_zero),
    .disp_o    (dec_disp)
  );

  rh_ea_gen #(
    .XLEN       (XLEN),
    .DISP_W     (DISP_W),
    .DISP_SHIFT (DISP_SHIFT)
  ) i_ea_gen (
    .base_i (ra_val_i),
    .disp_i (dec_disp),
    .ea_o   (ea_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      store_q   <= 1'b0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      trap_q    <= 1'b0;
      ea_q      <= '0;
      a_q       <= '0;
      b_q       <= '0;
      dig_q     <= '0;
      taddr_q   <= '0;
    end else begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      trap_q    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (instr_valid_i && dec_hit) begin
            if (!feat_en_i) begin
              done_q <= 1'b1;
            end else if (dec_ra_zero) begin
              done_q    <= 1'b1;
              illegal_q <= 1'b1;
            end else begin
              state_q <= ST_DIG;
              store_q <= dec_store;
              ea_q    <= ea_d;
              a_q     <= ra_val_i;
              b_q     <= rb_val_i;
            end
          end
        end
        ST_DIG: begin
          if (dig_ack_i) begin
            dig_q   <= dig_val_i;
            state_q <= ST_MEM;
          end
        end
        ST_MEM: begin
          if (mem_ack_i) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            if (!store_q && mem_rdata_i != dig_q) begin
              trap_q  <= 1'b1;
              taddr_q <= ea_q;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign illegal_o   = illegal_q;
  assign trap_o      = trap_q;
  assign trap_addr_o = taddr_q;
  assign dig_req_o   = (state_q == ST_DIG);
  assign dig_a_o     = a_q;
  assign dig_b_o     = b_q;
  assign mem_req_o   = (state_q == ST_MEM);
  assign mem_we_o    = store_q;
  assign mem_addr_o  = ea_q;
  assign mem_wdata_o = dig_q;
endmodule

// File: rtl/rh_exec_chk.sv
module rh_exec_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        done_o,
  input logic        illegal_o,
  input logic        trap_o,
  input logic        dig_req_o,
  input logic [63:0] dig_a_o,
  input logic [63:0] dig_b_o,
  input logic        dig_ack_i,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [63:0] mem_addr_o,
  input logic [63:0] mem_wdata_o,
  input logic        mem_ack_i
);
  a_r10_req_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dig_req_o && mem_req_o));

  a_r5_dig_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dig_req_o && !dig_ack_i |=> dig_req_o && $stable(dig_a_o) && $stable(dig_b_o));

  a_r10_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r9_busy_covers_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_req_o || mem_req_o) |-> busy_o);

  a_r8_trap_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> done_o && !illegal_o);

  a_r8_trap_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> !trap_o);

  a_r8_trap_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $past(mem_req_o && mem_ack_i && !mem_we_o));

  a_r3_illegal_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> done_o && !busy_o ##1 !illegal_o);
endmodule

bind rh_exec rh_exec_chk i_rh_exec_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .illegal_o   (illegal_o),
  .trap_o      (trap_o),
  .dig_req_o   (dig_req_o),
  .dig_a_o     (dig_a_o),
  .dig_b_o     (dig_b_o),
  .dig_ack_i   (dig_ack_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/test_rh_exec.sv
module test_rh_exec;
  localparam logic [9:0] XS = 10'b1011010010;
  localparam logic [9:0] XC = 10'b1011110010;

  typedef struct packed {
    logic        ill;
    logic        trp;
    logic [63:0] taddr;
  } exp_t;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        feat_en_i = 1'b1, instr_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [63:0] ra_val_i = '0, rb_val_i = '0;
  logic        busy_o, done_o, illegal_o, trap_o, dig_req_o, mem_req_o, mem_we_o;
  logic [63:0] trap_addr_o, dig_a_o, dig_b_o, mem_addr_o, mem_wdata_o;
  logic        dig_ack_i = 1'b0, mem_ack_i = 1'b0;
  logic [63:0] dig_val_i = '0, mem_rdata_i = '0;

  int checks = 0, errors = 0;
  bit finished = 0;
  exp_t exp_q[$];
  logic [63:0] mem_m [logic [63:0]];

  always #2.5 clk_i = ~clk_i;

  rh_exec i_rh_exec (.*);

  function automatic logic [63:0] digest(logic [63:0] a, logic [63:0] b);
    return (a * 64'h9E3779B97F4A7C15) ^ {b[31:0], b[63:32]} ^ 64'h0F0F_1234_5678_A5A5;
  endfunction

  function automatic logic [31:0] enc(logic [5:0] op, logic [9:0] xo, logic [4:0] raf, logic [5:0] d6);
    return {op, d6[4:0], raf, 5'd7, xo, d6[5]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (exp_q.size() == 0) begin
        chk(0, "R1/R9 unexpected completion", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(illegal_o == e.ill, "R3/R4 illegal flag", 64'(illegal_o), 64'(e.ill));
        chk(trap_o == e.trp, "R7/R8 trap flag", 64'(trap_o), 64'(e.trp));
        if (e.trp) chk(trap_addr_o == e.taddr, "R8 trap address", trap_addr_o, e.taddr);
      end
    end
  end

  // driver: issues one word and plays digest engine and memory
  task automatic issue(input logic [31:0] ins, input logic [63:0] ra, input logic [63:0] rb,
                       input bit feat, input bit busy_poke);
    bit hit, st;
    logic [63:0] ea, dg, rd;
    exp_t e;
    hit = (ins[31:26] == 6'd31) && (ins[10:1] == XS || ins[10:1] == XC);
    st  = (ins[10:1] == XS);
    ea  = ra + (64'hFFFF_FFFF_FFFF_FE00 | {55'd0, ins[0], ins[25:21], 3'b000});
    dg  = digest(ra, rb);
    e   = '0;
    if (hit && feat && ins[20:16] == 5'd0) e.ill = 1'b1;
    if (hit && feat && ins[20:16] != 5'd0 && !st) begin
      rd = mem_m.exists(ea) ? mem_m[ea] : 64'd0;
      e.trp = (rd != dg);
      e.taddr = ea;
    end
    if (hit) exp_q.push_back(e);
    feat_en_i = feat; instr_i = ins; ra_val_i = ra; rb_val_i = rb; instr_valid_i = 1'b1;
    @(negedge clk_i);
    instr_valid_i = 1'b0; ra_val_i = '1; rb_val_i = '1;
    if (!(hit && feat && ins[20:16] != 5'd0)) begin
      chk(!busy_o && !dig_req_o && !mem_req_o, "R1/R3/R4 no request", 64'(busy_o), 64'd0);
      @(negedge clk_i);
      chk(!done_o && !busy_o, "R1/R3/R4 idle after", 64'(done_o), 64'd0);
      return;
    end
    chk(dig_req_o && busy_o, "R5 digest request", 64'(dig_req_o), 64'd1);
    chk(dig_a_o == ra, "R5 operand a", dig_a_o, ra);
    chk(dig_b_o == rb, "R5 operand b", dig_b_o, rb);
    @(negedge clk_i);
    chk(dig_req_o && dig_a_o == ra && !mem_req_o, "R5 held", dig_a_o, ra);
    dig_ack_i = 1'b1; dig_val_i = dg;
    @(negedge clk_i);
    dig_ack_i = 1'b0; dig_val_i = '0;
    chk(mem_req_o && !dig_req_o && busy_o, "R10 memory request", 64'(mem_req_o), 64'd1);
    chk(mem_addr_o == ea, "R2 effective address", mem_addr_o, ea);
    chk(mem_we_o == st, st ? "R6 write direction" : "R7 read direction", 64'(mem_we_o), 64'(st));
    if (st) chk(mem_wdata_o == dg, "R6 write data", mem_wdata_o, dg);
    if (busy_poke) begin
      instr_i = enc(6'd31, XS, 5'd3, 6'd5); ra_val_i = 64'h5000; instr_valid_i = 1'b1;
    end
    @(negedge clk_i);
    instr_valid_i = 1'b0;
    chk(mem_req_o && mem_addr_o == ea, "R10 memory held", mem_addr_o, ea);
    if (st) mem_m[ea] = mem_wdata_o;
    mem_rdata_i = mem_m.exists(ea) ? mem_m[ea] : 64'd0;
    mem_ack_i = 1'b1;
    @(negedge clk_i);
    mem_ack_i = 1'b0; mem_rdata_i = '0;
    chk(!busy_o && !mem_req_o, "R9 busy drops at completion", 64'(busy_o), 64'd0);
    @(negedge clk_i);
    chk(!busy_o && !dig_req_o, "R9 word during busy ignored", 64'(busy_o), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !trap_o && !illegal_o && !dig_req_o && !mem_req_o,
        "R9 reset state", 64'(busy_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R6 store at lowest offset, R7 matching check
    issue(enc(6'd31, XS, 5'd1, 6'd0), 64'h1000, 64'hAAAA_0000_1111_2222, 1'b1, 1'b0);
    issue(enc(6'd31, XC, 5'd1, 6'd0), 64'h1000, 64'hAAAA_0000_1111_2222, 1'b1, 1'b0);
    // R2 highest offset -8, R9 word while busy
    issue(enc(6'd31, XS, 5'd9, 6'd63), 64'h2000_0008, 64'h1234, 1'b1, 1'b1);
    // R8 mismatch on changed RB
    issue(enc(6'd31, XC, 5'd9, 6'd63), 64'h2000_0008, 64'h1235, 1'b1, 1'b0);
    // R2 top field bit from instr[0]
    issue(enc(6'd31, XS, 5'd4, 6'h21), 64'hFFFF_0000_0000_0040, 64'hDEAD_BEEF, 1'b1, 1'b0);
    issue(enc(6'd31, XC, 5'd4, 6'h21), 64'hFFFF_0000_0000_0040, 64'hDEAD_BEEF, 1'b1, 1'b1);
    // R2 wrap below zero, R8 check of never-written slot
    issue(enc(6'd31, XC, 5'd2, 6'd10), 64'h100, 64'h77, 1'b1, 1'b0);
    // R3 zero base field
    issue(enc(6'd31, XS, 5'd0, 6'd3), 64'h3000, 64'h1, 1'b1, 1'b0);
    issue(enc(6'd31, XC, 5'd0, 6'd3), 64'h3000, 64'h1, 1'b1, 1'b0);
    // R4 feature off, including zero base field
    issue(enc(6'd31, XS, 5'd5, 6'd3), 64'h3000, 64'h1, 1'b0, 1'b0);
    issue(enc(6'd31, XC, 5'd0, 6'd3), 64'h3000, 64'h1, 1'b0, 1'b0);
    // R1 wrong extended opcode and wrong primary opcode
    issue(enc(6'd31, 10'b1011010011, 5'd5, 6'd3), 64'h3000, 64'h1, 1'b1, 1'b0);
    issue(enc(6'd30, XS, 5'd5, 6'd3), 64'h3000, 64'h1, 1'b1, 1'b0);
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R1 all completions seen", 64'(exp_q.size()), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule